// File: doc/BRIEF.md
# Shared Shift-and-Add Constant Multiplier (x23, x81)

This block takes one signed two's-complement sample and returns its products with two fixed integer constants, 23 and 81, on two separate outputs at the same time. It contains no multiplier. A small graph of three adders built from shifted copies of the sample produces both products. The common term 9x is computed once and used for both results. Both results depend on 9x, so the graph is two adder levels deep.

A parameter selects the timing. In pipelined mode there is one register stage per adder level, so results and their valid strobe appear two clock cycles after the sample. In combinational mode the products follow the input within the same cycle and the valid strobe passes straight through. The block sits in front of a filter tap line or any datapath that needs several fixed multiples of one value.

Top module: `mcm_const_mult`

## Requirements
- R1: `prod23` equals 23 times the signed sample `x_in`, as a signed value of W+7 bits.
- R2: `prod81` equals 81 times the signed sample `x_in`, as a signed value of W+7 bits. It is produced from the shared 9x term.
- R3: Both products are exact for every input, including the largest positive value (2^(W-1)-1) and the most negative value (-2^(W-1)).
- R4: With PIPELINED=1, `out_valid` is `in_valid` delayed by exactly two clock cycles. The products shown while it is high belong to the sample taken at that earlier cycle.
- R5: With PIPELINED=0, `out_valid` equals `in_valid`, and both products correspond to the current `x_in` without any clock edge in between.
- R6: A synchronous active-high `rst` clears the valid pipeline. Samples in flight when reset is taken never produce a high `out_valid`, and `out_valid` stays low until a new valid sample has passed through.
- R7: Samples presented on every consecutive cycle each produce one result, one per cycle, in input order, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the valid pipeline |
| in_valid | input | 1 | Marks `x_in` as a sample to process |
| x_in | input | W | Signed two's-complement sample |
| out_valid | output | 1 | Marks the products as belonging to a processed sample |
| prod23 | output | W+7 | Signed product 23·x |
| prod81 | output | W+7 | Signed product 81·x |

## Verification
The hardest case is a sample that is in flight when reset is taken. That sample has already been captured in the first stage, and it must still disappear without ever raising `out_valid`. The bench drives a valid sample on one cycle and raises reset on the very next cycle. It then removes that sample from the expected queue and relies on the monitor to flag any result that has no matching expected item. The extreme input values are also driven back to back through both variants, so that a carry or a missing sign extension in the shifted operands shows up in the widest sums.

// File: rtl/mcm_pkg.sv
package mcm_pkg;

   // constants realised by the adder graph
   localparam int K_LO = 23;
   localparam int K_HI = 81;

   // shift amounts used by the graph: t = (x<<3)+x, hi = (t<<3)+t, lo = (x<<5)-t
   localparam int SH_T  = 3;
   localparam int SH_HI = 3;
   localparam int SH_LO = 5;

   // number of adder levels in the graph
   localparam int GRAPH_DEPTH = 2;

   // growth in bits needed to hold the largest product (81 < 2^7)
   localparam int PROD_GROWTH = 7;
   // growth in bits for the shared 9x term (9 < 2^4)
   localparam int MID_GROWTH  = 4;

   function automatic int prod_width(input int w);
      return w + PROD_GROWTH;
   endfunction

   function automatic int mid_width(input int w);
      return w + MID_GROWTH;
   endfunction

endpackage

// File: rtl/mcm_shift_addsub.sv
module mcm_shift_addsub #(
   parameter int IW_A = 8,
   parameter int IW_B = 8,
   parameter int OW   = 12,
   parameter int SH_A = 3,
   parameter int SH_B = 0,
   parameter int SUB  = 0,
   parameter int REG  = 1
) (
   input  logic                   clk,
   input  logic signed [IW_A-1:0] a,
   input  logic signed [IW_B-1:0] b,
   output logic signed [OW-1:0]   y
);

   // elaboration-time parameter checks
   if (OW < IW_A + SH_A) begin : g_bad_a
      $error("mcm_shift_addsub: OW too small for shifted operand a");
   end
   if (OW < IW_B + SH_B) begin : g_bad_b
      $error("mcm_shift_addsub: OW too small for shifted operand b");
   end
   if (SUB != 0 && SUB != 1) begin : g_bad_sub
      $error("mcm_shift_addsub: SUB must be 0 or 1");
   end
   if (REG != 0 && REG != 1) begin : g_bad_reg
      $error("mcm_shift_addsub: REG must be 0 or 1");
   end

   logic signed [OW-1:0] a_ext;
   logic signed [OW-1:0] b_ext;
   logic signed [OW-1:0] a_sh;
   logic signed [OW-1:0] b_sh;
   logic signed [OW-1:0] res;

   // sign-extend before shifting so negative inputs stay exact
   assign a_ext = OW'(a);
   assign b_ext = OW'(b);
   assign a_sh  = a_ext <<< SH_A;
   assign b_sh  = b_ext <<< SH_B;

   if (SUB == 1) begin : g_sub
      assign res = a_sh - b_sh;
   end else begin : g_add
      assign res = a_sh + b_sh;
   end

   if (REG == 1) begin : g_reg
      always_ff @(posedge clk) begin
         y <= res;
      end
   end else begin : g_comb
      assign y = res;
   end

endmodule

// File: rtl/mcm_data_delay.sv
module mcm_data_delay #(
   parameter int WD  = 8,
   parameter int REG = 1
) (
   input  logic          clk,
   input  logic [WD-1:0] d,
   output logic [WD-1:0] q
);

   if (WD < 1) begin : g_bad_wd
      $error("mcm_data_delay: WD must be at least 1");
   end

   if (REG == 1) begin : g_reg
      always_ff @(posedge clk) begin
         q <= d;
      end
   end else begin : g_pass
      assign q = d;
   end

endmodule

// File: rtl/mcm_valid_pipe.sv
module mcm_valid_pipe #(
   parameter int DEPTH = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);

   if (DEPTH < 0) begin : g_bad_depth
      $error("mcm_valid_pipe: DEPTH must not be negative");
   end

   if (DEPTH == 0) begin : g_pass
      assign q = d;
   end else begin : g_pipe
      logic [DEPTH-1:0] sr;
      always_ff @(posedge clk) begin
         if (rst) begin
            sr <= '0;
         end else begin
            sr[0] <= d;
            for (int i = 1; i < DEPTH; i++) begin
               sr[i] <= sr[i-1];
            end
         end
      end
      assign q = sr[DEPTH-1];
   end

endmodule

// File: rtl/mcm_const_mult.sv
module mcm_const_mult
   import mcm_pkg::*;
#(
   parameter int W         = 12,
   parameter int PIPELINED = 1,
   localparam int PW       = prod_width(W)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic signed [W-1:0]  x_in,
   output logic                 out_valid,
   output logic signed [PW-1:0] prod23,
   output logic signed [PW-1:0] prod81
);

   localparam int TW  = mid_width(W);
   localparam int LAT = (PIPELINED == 1) ? GRAPH_DEPTH : 0;

   // elaboration-time parameter checks
   if (W < 2) begin : g_bad_w
      $error("mcm_const_mult: W must be at least 2");
   end
   if (PIPELINED != 0 && PIPELINED != 1) begin : g_bad_mode
      $error("mcm_const_mult: PIPELINED must be 0 or 1");
   end

   // level 1: shared term t9 = (x<<3) + x
   logic signed [TW-1:0] t9;
   logic signed [W-1:0]  x_d;

   mcm_shift_addsub #(
      .IW_A(W), .IW_B(W), .OW(TW),
      .SH_A(SH_T), .SH_B(0), .SUB(0), .REG(PIPELINED)
   ) u_lvl1_t9 (
      .clk(clk), .a(x_in), .b(x_in), .y(t9)
   );

   // x aligned with t9 for the level-2 subtraction
   mcm_data_delay #(
      .WD(W), .REG(PIPELINED)
   ) u_lvl1_xd (
      .clk(clk), .d(x_in), .q(x_d)
   );

   // level 2: hi = (t9<<3) + t9 = 81x
   mcm_shift_addsub #(
      .IW_A(TW), .IW_B(TW), .OW(PW),
      .SH_A(SH_HI), .SH_B(0), .SUB(0), .REG(PIPELINED)
   ) u_lvl2_hi (
      .clk(clk), .a(t9), .b(t9), .y(prod81)
   );

   // level 2: lo = (x<<5) - t9 = 23x
   mcm_shift_addsub #(
      .IW_A(W), .IW_B(TW), .OW(PW),
      .SH_A(SH_LO), .SH_B(0), .SUB(1), .REG(PIPELINED)
   ) u_lvl2_lo (
      .clk(clk), .a(x_d), .b(t9), .y(prod23)
   );

   mcm_valid_pipe #(
      .DEPTH(LAT)
   ) u_vld (
      .clk(clk), .rst(rst), .d(in_valid), .q(out_valid)
   );

endmodule

module mcm_const_mult_chk
   import mcm_pkg::*;
#(
   parameter int W         = 12,
   parameter int PIPELINED = 1
) (
   input logic                           clk,
   input logic                           rst,
   input logic                           in_valid,
   input logic signed [W-1:0]            x_in,
   input logic                           out_valid,
   input logic signed [prod_width(W)-1:0] prod23,
   input logic signed [prod_width(W)-1:0] prod81,
   input logic signed [mid_width(W)-1:0]  t9
);

   localparam int PW = prod_width(W);
   localparam int TW = mid_width(W);

   function automatic logic signed [PW-1:0] scale_p(input logic signed [W-1:0] v, input int k);
      logic signed [PW-1:0] ve;
      logic signed [PW-1:0] ke;
      ve = PW'(v);
      ke = PW'(k);
      return ve * ke;
   endfunction

   function automatic logic signed [TW-1:0] scale_t(input logic signed [W-1:0] v);
      logic signed [TW-1:0] ve;
      ve = TW'(v);
      return ve * TW'(9);
   endfunction

   // cycles since reset release, saturating
   logic [1:0] since_rst;
   always_ff @(posedge clk) begin
      if (rst) begin
         since_rst <= '0;
      end else if (since_rst != 2'd3) begin
         since_rst <= since_rst + 2'd1;
      end
   end

   if (PIPELINED == 1) begin : g_pipe
      assert_prod23_R1: assert property (@(posedge clk) disable iff (rst)
         out_valid |-> prod23 == scale_p($past(x_in, 2), K_LO));
      assert_prod81_R2: assert property (@(posedge clk) disable iff (rst)
         out_valid |-> prod81 == scale_p($past(x_in, 2), K_HI));
      // shared term (R2) follows the sample one cycle later
      assert_shared_R2: assert property (@(posedge clk) disable iff (rst)
         (since_rst != 2'd0) |-> t9 == scale_t($past(x_in)));
      assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
         (since_rst >= 2'd2) |-> out_valid == $past(in_valid, 2));
   end else begin : g_comb
      assert_comb_R5: assert property (@(posedge clk) disable iff (rst)
         in_valid |-> out_valid && prod23 == scale_p(x_in, K_LO)
                      && prod81 == scale_p(x_in, K_HI));
      assert_shared_R2: assert property (@(posedge clk) disable iff (rst)
         t9 == scale_t(x_in));
      assert_novalid_R5: assert property (@(posedge clk) disable iff (rst)
         !in_valid |-> !out_valid);
      assert_sat_R3: assert property (@(posedge clk) disable iff (rst)
         (x_in[W-1] && in_valid) |-> (prod23[PW-1] || x_in == '0));
   end

endmodule

bind mcm_const_mult mcm_const_mult_chk #(
   .W(W), .PIPELINED(PIPELINED)
) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in),
   .out_valid(out_valid), .prod23(prod23), .prod81(prod81), .t9(t9)
);

// File: tb/mcm_const_mult_test.sv
module mcm_const_mult_test;

   localparam int W  = 12;
   localparam int PW = W + 7;
   localparam logic signed [W-1:0] XMAX = {1'b0, {(W-1){1'b1}}};
   localparam logic signed [W-1:0] XMIN = {1'b1, {(W-1){1'b0}}};

   typedef struct {
      logic signed [W-1:0] x;
      int                  cyc;
   } item_t;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 in_valid = 1'b0;
   logic signed [W-1:0]  x_in = '0;
   logic                 v_pipe, v_comb;
   logic signed [PW-1:0] p23_pipe, p81_pipe, p23_comb, p81_comb;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int sent_pipe = 0;
   int recv_pipe = 0;
   bit done = 1'b0;

   item_t q_pipe[$];
   item_t q_comb[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   mcm_const_mult #(.W(W), .PIPELINED(1)) uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in),
      .out_valid(v_pipe), .prod23(p23_pipe), .prod81(p81_pipe)
   );

   mcm_const_mult #(.W(W), .PIPELINED(0)) uut_comb (
      .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in),
      .out_valid(v_comb), .prod23(p23_comb), .prod81(p81_comb)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic string tagx(input logic signed [W-1:0] v, input string base);
      if (v == XMAX || v == XMIN) return {base, " R3"};
      return base;
   endfunction

   // driver: one sample per call, pushes expected items
   task automatic drive(input logic signed [W-1:0] v, input bit vld);
      item_t it;
      @(negedge clk);
      x_in     = v;
      in_valid = vld;
      if (vld) begin
         it.x   = v;
         it.cyc = cyc;
         q_comb.push_back(it);
         if (!rst) begin
            q_pipe.push_back(it);
            sent_pipe++;
         end
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive('0, 1'b0);
   endtask

   // monitor: compares outputs against behavioural products
   always begin
      item_t it;
      @(posedge clk);
      #2;
      if (v_pipe === 1'b1) begin
         if (q_pipe.size() == 0) begin
            check("R6 pipelined valid with no pending sample", 1, 0);
         end else begin
            it = q_pipe.pop_front();
            recv_pipe++;
            check(tagx(it.x, "R1 pipelined prod23"), int'(p23_pipe), int'(it.x) * 23);
            check(tagx(it.x, "R2 pipelined prod81"), int'(p81_pipe), int'(it.x) * 81);
            check("R4 pipelined latency", cyc - it.cyc, 2);
         end
      end
      if (v_comb === 1'b1) begin
         if (q_comb.size() == 0) begin
            check("R5 comb valid with no pending sample", 1, 0);
         end else begin
            it = q_comb.pop_front();
            check(tagx(it.x, "R5 R1 comb prod23"), int'(p23_comb), int'(it.x) * 23);
            check(tagx(it.x, "R5 R2 comb prod81"), int'(p81_comb), int'(it.x) * 81);
            check("R5 comb same-cycle", cyc - it.cyc, 1);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R7 actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic signed [W-1:0] corners [6];
      corners = '{'0, 12'sd1, -12'sd1, XMAX, XMIN, 12'sd5};

      repeat (3) @(negedge clk);
      // reset state
      check("R6 pipelined valid in reset", int'(v_pipe), 0);
      check("R5 comb valid follows input in reset", int'(v_comb), 0);
      @(negedge clk);
      rst = 1'b0;
      idle(3);
      check("R6 pipelined valid after reset", int'(v_pipe), 0);

      // corner values, isolated
      foreach (corners[i]) begin
         drive(corners[i], 1'b1);
         idle(3);
      end
      // corner values, back to back (R3, R7)
      foreach (corners[i]) drive(corners[i], 1'b1);
      drive(XMIN, 1'b1);
      drive(XMIN, 1'b1);
      drive(XMAX, 1'b1);
      idle(4);

      // reset while a sample is in flight (R6)
      drive(12'sd77, 1'b1);
      @(negedge clk);
      rst      = 1'b1;
      in_valid = 1'b0;
      q_pipe.pop_back();
      sent_pipe--;
      @(negedge clk);
      check("R6 in-flight sample dropped during reset", int'(v_pipe), 0);
      @(negedge clk);
      check("R6 valid low while reset held", int'(v_pipe), 0);
      rst = 1'b0;
      idle(4);
      check("R6 no stray valid after reset release", int'(v_pipe), 0);

      // back-to-back random stream (R7)
      for (int i = 0; i < 300; i++) drive(W'($urandom), 1'b1);
      idle(4);
      check("R7 stream fully drained", q_pipe.size(), 0);
      check("R7 results equal samples sent", recv_pipe, sent_pipe);

      // random values with random gaps
      for (int i = 0; i < 300; i++) drive(W'($urandom), 1'($urandom));
      idle(5);
      check("R4 pipelined queue empty at end", q_pipe.size(), 0);
      check("R5 comb queue empty at end", q_comb.size(), 0);
      check("R7 total results equal samples sent", recv_pipe, sent_pipe);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule